// File: doc/BRIEF.md
# Display RAM Address Pointer

This block holds the column pointer (X, 0 to 101) and the bank pointer (Y, 0 to 8) for a byte-wide display memory of 9 banks by 102 columns. A host first places the pointer with load strobes. Each read or write pulse then uses the current pointer and, depending on the mode, moves it one step. The step either runs along a bank and carries into the next bank, or runs down a column and carries into the next column.

From the pointer the block derives four outputs for the memory beside it. The first is a linear byte index. The second is the physical column, which is mirrored when that mode is on. The third is a byte mask: in the last bank only the top bit of each byte exists. The fourth is a one-cycle error pulse, raised when a load carries an out-of-range value.

Each cycle is decoded into one of three named actions: ACT_HOLD keeps the pointer, ACT_LOAD applies the load strobes, and ACT_STEP advances the pointer. The three mode bits (column-first scan, read-modify-write, mirror) are held in registers and loaded with a configuration strobe.

Top module: `dram_addr_ptr`

## Requirements
- R1: After reset, ptr_x = 0, ptr_y = 0 and load_err = 0. All three mode bits are 0: row scan, read-modify-write off, no mirror.
- R2: ptr_x stays within 0..101 and ptr_y stays within 0..8 at all times.
- R3: With cfg_vert = 0, each step raises ptr_x by one. A step from ptr_x = 101 sets ptr_x to 0 and raises ptr_y by one.
- R4: With cfg_vert = 1, each step raises ptr_y by one. A step from ptr_y = 8 sets ptr_y to 0 and raises ptr_x by one.
- R5: In either scan order, a step from ptr_x = 101, ptr_y = 8 returns both pointers to 0.
- R6: A write pulse (acc_wr = 1) always causes a step. A read pulse alone (acc_rd = 1, acc_wr = 0) causes a step only when read-modify-write is off; otherwise the pointer holds.
- R7: With mirror on, phys_col = 101 − ptr_x. With mirror off, phys_col = ptr_x.
- R8: byte_idx = ptr_y × 102 + ptr_x, which spans 0..917.
- R9: bank_mask is 8'h80 when ptr_y = 8 and 8'hFF in every other bank.
- R10: A load of X above 101 or of Y above 8 leaves that pointer unchanged. For such a load, load_err is 1 for exactly the cycle after the strobe.
- R11: When a load strobe and an access pulse arrive in the same cycle, only the load takes effect; no step is applied in that cycle.
- R12: The mode bits written with cfg_we take effect from the next cycle. An access pulse in the same cycle as cfg_we steps according to the previous modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the three mode bits |
| cfg_vert | input | 1 | Column-first scan order when 1 |
| cfg_rmw | input | 1 | Read-modify-write: reads do not step |
| cfg_mirror | input | 1 | Mirror the physical column |
| ld_x | input | 1 | Load strobe for X |
| ld_x_val | input | 7 | New X value |
| ld_y | input | 1 | Load strobe for Y |
| ld_y_val | input | 4 | New Y value |
| acc_wr | input | 1 | Write-access pulse |
| acc_rd | input | 1 | Read-access pulse |
| ptr_x | output | 7 | Current X pointer |
| ptr_y | output | 4 | Current Y pointer |
| byte_idx | output | 10 | Linear byte index |
| phys_col | output | 7 | Physical column number |
| bank_mask | output | 8 | Bits stored in the current bank |
| load_err | output | 1 | One-cycle pulse after an out-of-range load |

## Verification
On every cycle the assertions check the following: the pointer range, the single-step rules in both scan orders, the return to zero from the final address, the hold on a read in read-modify-write mode, load priority over access, the rejection of a bad load with its error pulse, and the column and mask mapping. Some behaviour can only be shown by the bench's scenarios. These are a full sweep of all 918 addresses in both orders, checked against an independent linear-order model. Also covered are the mode change that coincides with an access, a load of both pointers where only one value is legal, and the mirrored column at both edges.

// File: rtl/dram_ptr_pkg.sv
package dram_ptr_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } ptr_act_e;
endpackage

// File: rtl/dram_xy_step.sv
module dram_xy_step #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    parameter int XW    = $clog2(COLS),
    parameter int YW    = $clog2(BANKS)
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          col_first,
    output logic [XW-1:0] nxt_x,
    output logic [YW-1:0] nxt_y
);
    localparam logic [XW-1:0] X_END = XW'(COLS - 1);
    localparam logic [YW-1:0] Y_END = YW'(BANKS - 1);

    logic x_end, y_end;
    logic [XW-1:0] x_inc;
    logic [YW-1:0] y_inc;

    assign x_end = (cur_x == X_END);
    assign y_end = (cur_y == Y_END);
    assign x_inc = x_end ? '0 : cur_x + 1'b1;
    assign y_inc = y_end ? '0 : cur_y + 1'b1;

    always_comb begin
        if (col_first) begin
            nxt_y = y_inc;
            nxt_x = y_end ? x_inc : cur_x;
        end else begin
            nxt_x = x_inc;
            nxt_y = x_end ? y_inc : cur_y;
        end
    end
endmodule

// File: rtl/dram_col_map.sv
module dram_col_map #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    parameter int DW    = 8,
    parameter int XW    = $clog2(COLS),
    parameter int YW    = $clog2(BANKS),
    parameter int IW    = $clog2(COLS * BANKS),
    parameter bit LAST_PARTIAL = 1'b1,
    parameter logic [DW-1:0] LAST_MASK = {1'b1, {(DW-1){1'b0}}}
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          mirror,
    output logic [IW-1:0] lin_idx,
    output logic [XW-1:0] col_out,
    output logic [DW-1:0] mask_out
);
    localparam logic [XW-1:0] X_END = XW'(COLS - 1);
    localparam logic [YW-1:0] Y_END = YW'(BANKS - 1);

    assign lin_idx = IW'(cur_y) * IW'(COLS) + IW'(cur_x);
    assign col_out = mirror ? (X_END - cur_x) : cur_x;

    generate
        if (LAST_PARTIAL) begin : g_partial
            assign mask_out = (cur_y == Y_END) ? LAST_MASK : '1;
        end else begin : g_full
            assign mask_out = '1;
        end
    endgenerate

    // R7: the physical column never leaves the column range
    always_comb begin
        assert_col_in_range_R7: assert (col_out <= X_END);
    end
endmodule

// File: rtl/dram_addr_ptr.sv
module dram_addr_ptr
    import dram_ptr_pkg::*;
#(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    parameter int DW    = 8,
    parameter int XW    = $clog2(COLS),
    parameter int YW    = $clog2(BANKS),
    parameter int IW    = $clog2(COLS * BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_vert,
    input  logic          cfg_rmw,
    input  logic          cfg_mirror,
    input  logic          ld_x,
    input  logic [XW-1:0] ld_x_val,
    input  logic          ld_y,
    input  logic [YW-1:0] ld_y_val,
    input  logic          acc_wr,
    input  logic          acc_rd,
    output logic [XW-1:0] ptr_x,
    output logic [YW-1:0] ptr_y,
    output logic [IW-1:0] byte_idx,
    output logic [XW-1:0] phys_col,
    output logic [DW-1:0] bank_mask,
    output logic          load_err
);
    localparam logic [XW-1:0] X_END = XW'(COLS - 1);
    localparam logic [YW-1:0] Y_END = YW'(BANKS - 1);

    logic mode_vert, mode_rmw, mode_mirror;
    logic [XW-1:0] x_q, x_d, x_step;
    logic [YW-1:0] y_q, y_d, y_step;
    logic err_d;
    logic x_ok, y_ok, load_any, step_req;
    ptr_act_e act;

    assign x_ok     = (ld_x_val <= X_END);
    assign y_ok     = (ld_y_val <= Y_END);
    assign load_any = ld_x | ld_y;
    assign step_req = acc_wr | (acc_rd & ~mode_rmw);

    dram_xy_step #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_step (
        .cur_x     (x_q),
        .cur_y     (y_q),
        .col_first (mode_vert),
        .nxt_x     (x_step),
        .nxt_y     (y_step)
    );

    dram_col_map #(.COLS(COLS), .BANKS(BANKS), .DW(DW), .XW(XW), .YW(YW), .IW(IW)) u_map (
        .cur_x    (x_q),
        .cur_y    (y_q),
        .mirror   (mode_mirror),
        .lin_idx  (byte_idx),
        .col_out  (phys_col),
        .mask_out (bank_mask)
    );

    always_comb begin
        if (load_any)      act = ACT_LOAD;
        else if (step_req) act = ACT_STEP;
        else               act = ACT_HOLD;
    end

    always_comb begin
        x_d   = x_q;
        y_d   = y_q;
        err_d = 1'b0;
        unique case (act)
            ACT_HOLD: ;
            ACT_LOAD: begin
                if (ld_x && x_ok) x_d = ld_x_val;
                if (ld_y && y_ok) y_d = ld_y_val;
                err_d = (ld_x && !x_ok) || (ld_y && !y_ok);
            end
            ACT_STEP: begin
                x_d = x_step;
                y_d = y_step;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q         <= '0;
            y_q         <= '0;
            load_err    <= 1'b0;
            mode_vert   <= 1'b0;
            mode_rmw    <= 1'b0;
            mode_mirror <= 1'b0;
        end else begin
            x_q      <= x_d;
            y_q      <= y_d;
            load_err <= err_d;
            if (cfg_we) begin
                mode_vert   <= cfg_vert;
                mode_rmw    <= cfg_rmw;
                mode_mirror <= cfg_mirror;
            end
        end
    end

    assign ptr_x = x_q;
    assign ptr_y = y_q;

    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_x <= X_END) && (ptr_y <= Y_END));

    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_any && step_req && !mode_vert && ptr_x != X_END)
        |=> (ptr_x == $past(ptr_x) + 1'b1) && $stable(ptr_y));

    assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_any && step_req && mode_vert && ptr_y != Y_END)
        |=> (ptr_y == $past(ptr_y) + 1'b1) && $stable(ptr_x));

    assert_final_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_any && step_req && ptr_x == X_END && ptr_y == Y_END)
        |=> (ptr_x == '0) && (ptr_y == '0));

    assert_rmw_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_any && acc_rd && !acc_wr && mode_rmw)
        |=> $stable(ptr_x) && $stable(ptr_y));

    assert_bad_x_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_x && ld_x_val > X_END) |=> load_err && $stable(ptr_x));

    assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_any) |=> !load_err);

    assert_load_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_x && ld_x_val <= X_END && (acc_wr || acc_rd)) |=> ptr_x == $past(ld_x_val));

    assert_load_y_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_y && !ld_x) |=> $stable(ptr_x));

    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_y != Y_END) |-> (bank_mask == '1));
endmodule

// File: tb/dram_addr_ptr_tb.sv
module dram_addr_ptr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCOL = 102;
    localparam int NBANK = 9;
    localparam int NTOT = NCOL * NBANK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_vert = 0, cfg_rmw = 0, cfg_mirror = 0;
    logic ld_x = 0, ld_y = 0, acc_wr = 0, acc_rd = 0;
    logic [6:0] ld_x_val = '0;
    logic [3:0] ld_y_val = '0;
    logic [6:0] ptr_x, phys_col;
    logic [3:0] ptr_y;
    logic [9:0] byte_idx;
    logic [7:0] bank_mask;
    logic load_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_addr_ptr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vert(cfg_vert),
        .cfg_rmw(cfg_rmw), .cfg_mirror(cfg_mirror), .ld_x(ld_x), .ld_x_val(ld_x_val),
        .ld_y(ld_y), .ld_y_val(ld_y_val), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .byte_idx(byte_idx), .phys_col(phys_col),
        .bank_mask(bank_mask), .load_err(load_err)
    );

    typedef struct {
        int    x, y, idx, col, mask, err;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    int m_x = 0, m_y = 0;
    bit m_v = 0, m_r = 0, m_m = 0;

    task automatic check_now(string tag, int ax, int ay, int ai, int ac, int am, int ae,
                             int ex, int ey, int ei, int ec, int em, int ee);
        n_checks++;
        if (ax != ex || ay != ey || ai != ei || ac != ec || am != em || ae != ee) begin
            n_fail++;
            $display("FAIL %s: got x=%0d y=%0d idx=%0d col=%0d mask=%0h err=%0d, expected x=%0d y=%0d idx=%0d col=%0d mask=%0h err=%0d",
                     tag, ax, ay, ai, ac, am, ae, ex, ey, ei, ec, em, ee);
        end
    endtask

    task automatic drive(bit lx, int vx, bit ly, int vy, bit wr, bit rd,
                         bit cw, bit cv, bit cr, bit cm, string tag);
        exp_t e;
        int lin;
        bit bad;
        @(negedge clk);
        ld_x = lx; ld_x_val = 7'(vx); ld_y = ly; ld_y_val = 4'(vy);
        acc_wr = wr; acc_rd = rd;
        cfg_we = cw; cfg_vert = cv; cfg_rmw = cr; cfg_mirror = cm;
        bad = 0;
        if (lx || ly) begin
            if (lx) begin if (vx < NCOL) m_x = vx; else bad = 1; end
            if (ly) begin if (vy < NBANK) m_y = vy; else bad = 1; end
        end else if (wr || (rd && !m_r)) begin
            if (m_v) begin
                lin = (m_x * NBANK + m_y + 1) % NTOT;
                m_x = lin / NBANK; m_y = lin % NBANK;
            end else begin
                lin = (m_y * NCOL + m_x + 1) % NTOT;
                m_y = lin / NCOL; m_x = lin % NCOL;
            end
        end
        if (cw) begin m_v = cv; m_r = cr; m_m = cm; end
        e.x = m_x; e.y = m_y; e.idx = m_y * NCOL + m_x;
        e.col = m_m ? (NCOL - 1 - m_x) : m_x;
        e.mask = (m_y == NBANK - 1) ? 8'h80 : 8'hFF;
        e.err = bad; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic set_mode(bit v, bit r, bit m, string tag);
        drive(0, 0, 0, 0, 0, 0, 1, v, r, m, tag);
    endtask

    task automatic put(int x, int y, string tag);
        drive(1, x, 1, y, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_now(e.tag, int'(ptr_x), int'(ptr_y), int'(byte_idx), int'(phys_col),
                          int'(bank_mask), int'(load_err),
                          e.x, e.y, e.idx, e.col, e.mask, e.err);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check_now("R1 reset", int'(ptr_x), int'(ptr_y), int'(byte_idx), int'(phys_col),
                  int'(bank_mask), int'(load_err), 0, 0, 0, 0, 8'hFF, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 idle after reset");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R1 default row scan");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1 default rmw off");

        // row scan with bank carry
        put(99, 0, "R11 load");
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R3 row step");
        put(101, 8, "R9 last bank");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 row final wrap");

        // full row-order sweep
        for (int i = 0; i < NTOT; i++) drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 R8 R9 row sweep");

        // column scan
        set_mode(1, 0, 0, "R12 set column scan");
        put(5, 7, "R11 load");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R4 column step");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R4 column carry");
        put(101, 8, "R11 load");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 column final wrap via read");
        for (int i = 0; i < NTOT; i++) drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 R4 column sweep");

        // read-modify-write
        set_mode(0, 1, 0, "R12 set rmw");
        put(10, 2, "R11 load");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 rmw read holds");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 rmw read holds again");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6 rmw write steps");
        drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R6 rmw read+write steps");
        set_mode(0, 0, 0, "R12 rmw off");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 read steps");

        // mode change coinciding with access uses old mode
        drive(0, 0, 0, 0, 1, 0, 1, 1, 0, 0, "R12 access with cfg_we");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R12 new mode active");

        // mirror
        set_mode(0, 0, 1, "R7 mirror on");
        put(0, 3, "R7 mirror x=0");
        put(101, 3, "R7 mirror x=101");
        put(40, 8, "R7 R9 mirror mid");
        set_mode(0, 0, 0, "R7 mirror off");

        // bad loads
        put(20, 4, "R11 load");
        drive(1, 102, 0, 0, 0, 0, 0, 0, 0, 0, "R10 bad x");
        idle("R10 err clears");
        drive(0, 0, 1, 9, 0, 0, 0, 0, 0, 0, "R10 bad y");
        drive(1, 127, 1, 15, 1, 0, 0, 0, 0, 0, "R10 R11 both bad with write");
        drive(1, 30, 1, 12, 0, 0, 0, 0, 0, 0, "R10 x good y bad");

        // load priority over access
        drive(1, 50, 0, 0, 1, 0, 0, 0, 0, 0, "R11 x load beats write");
        drive(0, 0, 1, 6, 0, 1, 0, 0, 0, 0, "R11 y load beats read");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R3 step after load");
        idle("R3 final idle");

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule